// File: doc/BRIEF.md
# SDLC Transmit Framer with Idle Control

This block turns bytes written one at a time into a bit-serial HDLC/SDLC line signal. Each byte is held in a one-byte buffer and then moved into a shift register. The register sends it least significant bit first. The framer wraps the data in a programmable 8-bit flag character. It inserts a zero after every five consecutive ones in the data and in the frame check sequence. When the buffer runs dry, it closes the frame with an inverted 16-bit CRC and a closing flag. Between frames the line carries whole 8-bit idle units, either all ones (mark) or flag characters.

All serial activity advances on a one-cycle bit-clock enable. Software-side logic writes a byte whenever the buffer-empty status is high. That status, and the optional interrupt pulse, tell it when to write the next byte. An auto-flag option covers a frame that starts while the line is mark idling: the framer inserts the opening flag itself and presets the CRC. Without the option, a byte written during mark idle goes onto the line with no opening flag.

Top module: `sdlc_tx_framer`

## Requirements
- R1: While `tx_enable` is low, `txd` is 1 and the shifter is stopped. Deasserting `tx_enable` during operation returns `txd` to 1.
- R2: Idle is sent in whole 8-bit units.
  - A flag unit is the `flag_char` value sent LSB first.
  - A mark unit is eight 1 bits.
  - When `mark_idle` goes low during mark idle, the current mark unit completes before flags begin. The run of ones before the first flag is therefore a multiple of 8.
- R3: A frame has four parts, in this order:
  - an opening flag;
  - every written byte, LSB first, with no gap;
  - the FCS, which starts as soon as a byte boundary finds the buffer empty;
  - a closing flag.

  After the closing flag the line returns to idle.
- R4: A 0 is inserted after every five consecutive 1 bits of data and FCS. The count carries across byte boundaries. No bit is inserted into flag or mark units.
- R5: The FCS is a CRC-16 over the data bits, using the reflected polynomial constant 0x8408 (x^16+x^12+x^5+1). It is sent inverted, LSB first. A `crc_reset_cmd` pulse loads the preset: 0xFFFF when `crc_preset_ones`=1, otherwise 0x0000.
- R6: Each serial bit reaches `txd` five bit ticks after it leaves the zero inserter. Suppose the framer is enabled with flag idle and the flag is 0x7E. The first 0 on `txd` then shows up at the sixth bit tick counted from the enabling tick, that is at index 5, counting from 0.
- R7: `buf_empty` behaves as follows:
  - It is 1 after reset.
  - It is 0 on the clock after a write.
  - It becomes 1 when a byte moves into the shifter.
  - It becomes 0 when the FCS is loaded and stays 0 while the FCS is sent.
  - It becomes 1 again when the closing flag is loaded.

  A frame of N bytes therefore produces N+1 rising edges.
- R8: `tx_irq` is a one-cycle pulse on each rising edge of `buf_empty` while `int_enable` is 1. No pulse occurs when `int_enable` is 0.
- R9: With `auto_flag`=0, a byte written during mark idle is sent directly after a mark unit, with no opening flag.
- R10: With `auto_flag`=1, a byte written during mark idle is preceded by an opening flag that follows the last mark unit, and the CRC is preset automatically with no command.
- R11: Raising `mark_idle` during flag idle does not switch the line to mark. Mark idle starts only after the closing flag of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-clock enable, one serial bit per pulse |
| tx_enable | input | 1 | Transmitter enable |
| mark_idle | input | 1 | 1 selects mark idle, 0 selects flag idle |
| auto_flag | input | 1 | Automatic opening flag and CRC preset out of mark idle |
| crc_preset_ones | input | 1 | CRC preset value: 1 = all ones, 0 = all zeros |
| crc_reset_cmd | input | 1 | Pulse: load CRC preset |
| flag_char | input | 8 | Flag character |
| wr_valid | input | 1 | Write strobe for the transmit buffer |
| wr_data | input | 8 | Byte to transmit |
| int_enable | input | 1 | Interrupt enable |
| buf_empty | output | 1 | Transmit buffer empty status |
| tx_irq | output | 1 | Interrupt pulse on buffer-empty rise |
| txd | output | 1 | Serial data output |

## Verification
Status timing is exact:
- `buf_empty` is sampled on the falling edge that follows each write strobe, and must already be low.
- `tx_irq` is counted in the same cycle as each `buf_empty` rise. A frame of N bytes must give N+1 pulses.

Serial timing is checked in two ways:
- After enabling, `txd` is sampled once per bit tick. The first flag zero must land at index 5, which checks the five-tick inserter latency.
- Each frame is checked against a bit stream the bench builds itself: flag, stuffed data, inverted CRC, flag. The bench locates this stream within a window around the writes. It then checks the 8 bits before the match and the 16 bits after it for the expected idle pattern. This keeps the checks independent of where a frame happens to start relative to the current idle unit.

// File: rtl/sdlc_tx_framer.sv
module sdlc_tx_framer #(
  parameter int BYTE_W = 8,
  parameter int FCS_W = 16,
  parameter int RUN_MAX = 5,
  parameter int LAT = 5,
  parameter logic [FCS_W-1:0] POLY = 16'h8408
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              tx_enable,
  input  logic              mark_idle,
  input  logic              auto_flag,
  input  logic              crc_preset_ones,
  input  logic              crc_reset_cmd,
  input  logic [BYTE_W-1:0] flag_char,
  input  logic              wr_valid,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              int_enable,
  output logic              buf_empty,
  output logic              tx_irq,
  output logic              txd
);
  localparam int CW = $clog2(FCS_W + 1);
  localparam int OW = $clog2(RUN_MAX + 1);

  typedef enum logic [2:0] {U_OFF, U_MARK, U_FLAG, U_DATA, U_FCS} unit_e;

  unit_e             cur, nxt;
  logic [FCS_W-1:0]  sh, crc, crc_step, crc_nx, preset;
  logic [CW-1:0]     cnt;
  logic [OW-1:0]     ones_c;
  logic              closing, buf_full, be_nx;
  logic [BYTE_W-1:0] buf_q;
  logic [LAT-1:0]    dly;
  logic              tick, stall, last, adv, stuffable, out_bit, auto_pre;

  assign tick      = bit_en && tx_enable;
  assign stall     = ones_c == OW'(RUN_MAX);
  assign last      = (cur == U_OFF) || (cnt == CW'(1));
  assign adv       = tick && !stall && last;
  assign stuffable = (cur == U_DATA) || (cur == U_FCS);
  assign out_bit   = !stall && ((cur == U_OFF) || sh[0]);
  assign preset    = crc_preset_ones ? '1 : '0;
  assign crc_step  = (crc >> 1) ^ ((crc[0] ^ sh[0]) ? POLY : '0);
  assign crc_nx    = (tick && !stall && cur == U_DATA) ? crc_step : crc;
  assign auto_pre  = adv && cur == U_MARK && buf_full && auto_flag;
  assign txd       = dly[LAT-1] | ~tx_enable;

  always_comb begin
    unique case (cur)
      U_DATA:  nxt = buf_full ? U_DATA : U_FCS;
      U_FCS:   nxt = U_FLAG;
      U_MARK:  nxt = buf_full ? (auto_flag ? U_FLAG : U_DATA)
                              : (mark_idle ? U_MARK : U_FLAG);
      U_FLAG:  nxt = buf_full ? U_DATA : ((mark_idle && closing) ? U_MARK : U_FLAG);
      default: nxt = mark_idle ? U_MARK : U_FLAG;
    endcase
  end

  always_comb begin
    if (wr_valid)                   be_nx = 1'b0;
    else if (adv && nxt == U_DATA)  be_nx = 1'b1;
    else if (adv && nxt == U_FCS)   be_nx = 1'b0;
    else if (adv && cur == U_FCS)   be_nx = 1'b1;
    else                            be_nx = buf_empty;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur       <= U_OFF;
      sh        <= '0;
      cnt       <= '0;
      ones_c    <= '0;
      closing   <= 1'b0;
      crc       <= '1;
      buf_full  <= 1'b0;
      buf_q     <= '0;
      buf_empty <= 1'b1;
      tx_irq    <= 1'b0;
      dly       <= '1;
    end else begin
      buf_empty <= be_nx;
      tx_irq    <= int_enable && be_nx && !buf_empty;

      if (wr_valid) begin
        buf_full <= 1'b1;
        buf_q    <= wr_data;
      end else if (adv && nxt == U_DATA) begin
        buf_full <= 1'b0;
      end

      if (crc_reset_cmd || auto_pre) crc <= preset;
      else                           crc <= crc_nx;

      if (!tx_enable) begin
        cur     <= U_OFF;
        cnt     <= '0;
        ones_c  <= '0;
        closing <= 1'b0;
        dly     <= '1;
      end else if (tick) begin
        dly <= {dly[LAT-2:0], out_bit};
        if (stall)                   ones_c <= '0;
        else if (stuffable && sh[0]) ones_c <= ones_c + OW'(1);
        else                         ones_c <= '0;

        if (adv) begin
          cur     <= nxt;
          cnt     <= (nxt == U_FCS) ? CW'(FCS_W) : CW'(BYTE_W);
          closing <= (cur == U_FCS);
          unique case (nxt)
            U_FLAG:  sh <= FCS_W'(flag_char);
            U_DATA:  sh <= FCS_W'(buf_q);
            U_FCS:   sh <= ~crc_nx;
            default: sh <= '1;
          endcase
        end else if (!stall) begin
          sh  <= sh >> 1;
          cnt <= cnt - CW'(1);
        end
      end
    end
  end
endmodule

module sdlc_tx_framer_chk #(
  parameter int RUN_MAX = 5
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           tx_enable,
  input logic                           wr_valid,
  input logic                           buf_empty,
  input logic                           tx_irq,
  input logic [2:0]                     cur,
  input logic [$clog2(RUN_MAX+1)-1:0]   ones_c
);
  assert_write_clears_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_valid) |-> !buf_empty);

  assert_fcs_keeps_empty_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == 3'd4) |-> !buf_empty);

  assert_irq_on_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> (buf_empty && !$past(buf_empty)));

  assert_run_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ones_c <= ($clog2(RUN_MAX+1))'(RUN_MAX));

  assert_disable_stops_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_enable |=> (cur == 3'd0));
endmodule

bind sdlc_tx_framer sdlc_tx_framer_chk #(.RUN_MAX(RUN_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .wr_valid(wr_valid),
  .buf_empty(buf_empty), .tx_irq(tx_irq), .cur(cur), .ones_c(ones_c)
);

// File: tb/sdlc_tx_framer_test.sv
module sdlc_tx_framer_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, bit_en = 1'b1, tx_enable = 1'b0, mark_idle = 1'b0;
  logic auto_flag = 1'b0, crc_preset_ones = 1'b1, crc_reset_cmd = 1'b0;
  logic [7:0] flag_char = 8'h7E, wr_data = 8'h00;
  logic wr_valid = 1'b0, int_enable = 1'b1;
  logic buf_empty, tx_irq, txd;

  sdlc_tx_framer uut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_enable(tx_enable),
    .mark_idle(mark_idle), .auto_flag(auto_flag), .crc_preset_ones(crc_preset_ones),
    .crc_reset_cmd(crc_reset_cmd), .flag_char(flag_char), .wr_valid(wr_valid),
    .wr_data(wr_data), .int_enable(int_enable), .buf_empty(buf_empty),
    .tx_irq(tx_irq), .txd(txd)
  );

  int nchk = 0, nfail = 0;
  bit finished = 1'b0;
  bit cap [0:4095];
  int ncap = 0, div = 1, dcnt = 0, irq_cnt = 0, be_rise = 0;
  bit tick_q = 1'b0, be_prev = 1'b1;
  int exp_b [0:1023];
  int nexp = 0, ones = 0;
  logic [7:0] dat [0:7];

  always @(posedge clk) tick_q <= bit_en && tx_enable;

  always @(negedge clk) begin
    if (tick_q) begin
      cap[ncap % 4096] = txd;
      ncap++;
    end
    if (tx_irq === 1'b1) irq_cnt++;
    if (buf_empty === 1'b1 && !be_prev) be_rise++;
    be_prev = (buf_empty === 1'b1);
    dcnt = (dcnt + 1 >= div) ? 0 : dcnt + 1;
    bit_en <= (dcnt == 0);
  end

  function automatic bit capb(input int i);
    return cap[i % 4096];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic [15:0] crc_step(input logic [15:0] c, input bit b);
    return (c[0] ^ b) ? ((c >> 1) ^ 16'h8408) : (c >> 1);
  endfunction

  task automatic push_raw(input bit b);
    exp_b[nexp] = b;
    nexp++;
  endtask

  task automatic push_stuff(input bit b);
    push_raw(b);
    if (b) ones++; else ones = 0;
    if (ones == 5) begin
      push_raw(1'b0);
      ones = 0;
    end
  endtask

  task automatic build(input int n, input bit open, input bit pre_ones);
    logic [15:0] c;
    nexp = 0;
    ones = 0;
    if (open) for (int k = 0; k < 8; k++) push_raw(flag_char[k]);
    c = pre_ones ? 16'hFFFF : 16'h0000;
    for (int i = 0; i < n; i++)
      for (int k = 0; k < 8; k++) begin
        c = crc_step(c, dat[i][k]);
        push_stuff(dat[i][k]);
      end
    c = ~c;
    for (int k = 0; k < 16; k++) push_stuff(c[k]);
    for (int k = 0; k < 8; k++) push_raw(flag_char[k]);
  endtask

  function automatic int find_exp(input int from);
    for (int p = from; p + nexp <= ncap; p++) begin
      bit ok = 1'b1;
      for (int j = 0; j < nexp; j++)
        if (capb(p + j) != exp_b[j]) begin ok = 1'b0; break; end
      if (ok) return p;
    end
    return -1;
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_byte(input logic [7:0] d);
    int g = 0;
    while (buf_empty !== 1'b1 && g < 4000) begin @(negedge clk); g++; end
    wr_valid = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    chk(buf_empty === 1'b0, "R7 empty cleared by write", int'(buf_empty), 0);
  endtask

  task automatic frame(input int n, input bit open, input bit pre_ones, input bit do_cmd,
                       input bit irq_on, output int p);
    int start, i0, b0, g;
    start = (ncap > 24) ? ncap - 24 : 0;
    crc_preset_ones = pre_ones;
    int_enable = irq_on;
    if (do_cmd) begin
      crc_reset_cmd = 1'b1;
      @(negedge clk);
      crc_reset_cmd = 1'b0;
    end
    i0 = irq_cnt;
    b0 = be_rise;
    for (int i = 0; i < n; i++) write_byte(dat[i]);
    g = 0;
    while (be_rise - b0 < n + 1 && g < 8000) begin @(negedge clk); g++; end
    wait_cyc(100 * div);
    chk(be_rise - b0 == n + 1, "R7 empty rises per frame", be_rise - b0, n + 1);
    chk(irq_cnt - i0 == (irq_on ? n + 1 : 0), "R8 irq pulses per frame",
        irq_cnt - i0, irq_on ? n + 1 : 0);
    int_enable = 1'b1;
    build(n, open, pre_ones);
    p = find_exp(start);
    chk(p >= 0, "R3 R4 R5 frame bit stream", p, 0);
  endtask

  task automatic check_idle_after(input int p, input bit mark, input string req);
    bit ok = 1'b1;
    int e = p + nexp;
    for (int j = 0; j < 16; j++)
      if (capb(e + j) != (mark ? 1'b1 : flag_char[j % 8])) ok = 1'b0;
    chk(ok && p >= 0, req, int'(ok), 1);
  endtask

  task automatic check_ones_before(input int p, input string req);
    bit ok = (p >= 8);
    for (int j = 1; j <= 8; j++) if (p >= 8 && capb(p - j) != 1'b1) ok = 1'b0;
    chk(ok, req, int'(ok), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int p, zeros, r, e;
    bit ok;
    wait_cyc(4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd === 1'b1, "R1 reset txd high", int'(txd), 1);
    chk(buf_empty === 1'b1, "R7 reset empty", int'(buf_empty), 1);
    chk(tx_irq === 1'b0, "R8 reset irq low", int'(tx_irq), 0);

    ok = 1'b1;
    repeat (20) begin @(negedge clk); if (txd !== 1'b1) ok = 1'b0; end
    chk(ok, "R1 disabled txd high", int'(ok), 1);

    mark_idle = 1'b0;
    tx_enable = 1'b1;
    wait_cyc(40);
    ok = 1'b1;
    for (int j = 0; j < 5; j++) if (cap[j] != 1'b1) ok = 1'b0;
    chk(ok && cap[5] == 1'b0, "R6 first flag zero at tick index 5", int'(cap[5]), 0);
    ok = 1'b1;
    for (int j = 0; j < 16; j++) if (cap[5 + j] != flag_char[j % 8]) ok = 1'b0;
    chk(ok, "R2 flag idle whole units", int'(ok), 1);

    for (int f = 0; f < 11; f++) begin
      int n = 1 + f % 4;
      div = (f < 6) ? 1 : 2;
      for (int i = 0; i < n; i++)
        dat[i] = (f % 4 == 3) ? 8'hFF : 8'((f * 53 + i * 29 + 7) & 255);
      frame(n, 1'b1, f % 3 != 2, 1'b1, f != 5, p);
      check_idle_after(p, 1'b0, "R2 flag idle after close");
    end

    mark_idle = 1'b1;
    wait_cyc(80 * div);
    zeros = 0;
    for (int j = 1; j <= 16; j++) if (capb(ncap - j) == 1'b0) zeros++;
    chk(zeros > 0, "R11 mark select ignored before frame", zeros, 4);

    dat[0] = 8'hA5; dat[1] = 8'h3E; dat[2] = 8'hF0;
    frame(3, 1'b1, 1'b1, 1'b1, 1'b1, p);
    check_idle_after(p, 1'b1, "R11 mark idle after close");

    wait_cyc(60 * div);
    auto_flag = 1'b0;
    dat[0] = 8'h3C; dat[1] = 8'h9F;
    frame(2, 1'b0, 1'b1, 1'b1, 1'b1, p);
    check_ones_before(p, "R9 no opening flag after mark");
    check_idle_after(p, 1'b1, "R9 mark idle resumes");

    wait_cyc(60 * div);
    auto_flag = 1'b1;
    dat[0] = 8'h12; dat[1] = 8'hFE; dat[2] = 8'h7E;
    frame(3, 1'b1, 1'b0, 1'b0, 1'b1, p);
    check_ones_before(p, "R10 auto opening flag after mark");
    check_idle_after(p, 1'b1, "R10 mark idle resumes");

    auto_flag = 1'b0;
    wait_cyc(37);
    mark_idle = 1'b0;
    wait_cyc(100 * div);
    e = p + nexp;
    r = 0;
    while (e + r < ncap && capb(e + r) == 1'b1) r++;
    chk(r >= 8 && r % 8 == 0, "R2 mark units complete before flags", r, 8 * (r / 8 + 1));
    ok = 1'b1;
    for (int j = 0; j < 8; j++) if (capb(e + r + j) != flag_char[j]) ok = 1'b0;
    chk(ok, "R2 flags follow mark idle", int'(ok), 1);

    tx_enable = 1'b0;
    @(negedge clk);
    ok = 1'b1;
    repeat (10) begin @(negedge clk); if (txd !== 1'b1) ok = 1'b0; end
    chk(ok, "R1 txd high after disable", int'(ok), 1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule